// File: doc/BRIEF.md
# Condition Code and Branch Resolver

This block holds the processor's four condition flags (negative, zero, overflow, carry) and decides whether a conditional branch is taken. Each instruction presents its ALU result, carry-out and overflow together with a two-bit update class. The class selects which flags the instruction writes. Arithmetic and compare operations write all four flags. Logical operations write only negative and zero. Shifts write only carry. Moves and most other operations write nothing.

At the same time, a branch presents a four-bit condition code, a signed word offset and its own program counter. The block tests the condition against the flags held in the register. It then reports whether the branch is taken, and gives the target address: the address of the next sequential instruction plus the offset scaled to bytes.

Top module: `cc_branch_unit`

## Requirements
- R1: While `rst_n` is low, and after any reset, `flags` reads 4'b0000. The layout of `flags` is {N, Z, V, C}, from bit 3 down to bit 0.
- R2: With update class 2'b01 (full), the edge sets the flags as follows: N takes the result's top bit, Z is set when the result is zero, V takes `alu_ovf` and C takes `alu_cout`. The new values appear on `flags` after that clock edge.
- R3: With update class 2'b10 (logic), N and Z are written as in R2. V and C keep their previous values.
- R4: With update class 2'b11 (shift), C takes `alu_cout`. N, Z and V keep their previous values.
- R5: With update class 2'b00 (none), all four flags are unchanged, whatever the ALU inputs are.
- R6: `br_taken` is 0 whenever `br_valid` is 0. Condition code 0 (always) is taken and code 1 (never) is not taken.
- R7: The signed conditions are taken on these terms:
  - code 2 (equal) when Z=1
  - code 3 (not equal) when Z=0
  - code 4 (greater) when Z=0 and N=V
  - code 5 (less-or-equal) when Z=1 or N≠V
  - code 6 (greater-or-equal) when N=V
  - code 7 (less) when N≠V
- R8: The remaining conditions are taken on these terms:
  - code 8 (unsigned greater) when C=1 and Z=0
  - code 9 (unsigned less-or-equal) when C=0 or Z=1
  - code 10 when C=0 and code 11 when C=1
  - code 12 when N=0 and code 13 when N=1
  - code 14 when V=0 and code 15 when V=1
- R9: `br_target` equals `pc + 4 + sign_extend(br_ofs) * 4`, truncated to ADDR_W bits. It is combinational and is valid whatever the condition is.
- R10: When a flag update and a branch test occur in the same cycle, the test uses the flags from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| upd_cls | input | 2 | Flag update class: 00 none, 01 full, 10 logic, 11 shift |
| alu_res | input | DATA_W | ALU result of the current instruction |
| alu_cout | input | 1 | ALU carry-out |
| alu_ovf | input | 1 | ALU signed overflow |
| br_valid | input | 1 | A branch is being evaluated this cycle |
| br_cond | input | 4 | Branch condition code (see R6 to R8) |
| br_ofs | input | OFS_W | Signed branch offset in instructions |
| pc | input | ADDR_W | Address of the branch instruction |
| br_taken | output | 1 | Branch is taken |
| br_target | output | ADDR_W | Branch target address |
| flags | output | 4 | Current flags {N, Z, V, C} |

## Verification
The bench builds the block with DATA_W=8, ADDR_W=16 and OFS_W=16. The narrow result makes the all-zero and top-bit-set results that drive Z and N trivial to produce. The 16-bit address space lets a small program counter plus a forward offset wrap past the top of memory. Because the offset is as wide as the address, the scaled offset is wider than the address, so truncation of the sum is exercised in both directions. Every condition code is tested against every flag combination the update path can reach.

// File: rtl/cc_pkg.sv
package cc_pkg;

  typedef enum logic [1:0] {
    UPD_NONE  = 2'b00,
    UPD_FULL  = 2'b01,
    UPD_LOGIC = 2'b10,
    UPD_SHIFT = 2'b11
  } upd_cls_e;

  typedef enum logic [3:0] {
    CND_ALWAYS = 4'd0,
    CND_NEVER  = 4'd1,
    CND_EQ     = 4'd2,
    CND_NE     = 4'd3,
    CND_GT     = 4'd4,
    CND_LE     = 4'd5,
    CND_GE     = 4'd6,
    CND_LT     = 4'd7,
    CND_UGT    = 4'd8,
    CND_ULE    = 4'd9,
    CND_CCLR   = 4'd10,
    CND_CSET   = 4'd11,
    CND_POS    = 4'd12,
    CND_NEG    = 4'd13,
    CND_VCLR   = 4'd14,
    CND_VSET   = 4'd15
  } cond_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;

endpackage

// File: rtl/cc_flag_reg.sv
module cc_flag_reg
  import cc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  upd_cls_e          cls,
  input  logic [DATA_W-1:0] res,
  input  logic              cout,
  input  logic              ovf,
  output flags_t            q
);

  flags_t d;
  logic   en;
  logic   res_zero;
  logic   res_neg;

  assign res_zero = (res == '0);
  assign res_neg  = res[DATA_W-1];
  assign en       = (cls != UPD_NONE);

  always_comb begin
    d = q;
    unique case (cls)
      UPD_FULL: begin
        d.n = res_neg;
        d.z = res_zero;
        d.v = ovf;
        d.c = cout;
      end
      UPD_LOGIC: begin
        d.n = res_neg;
        d.z = res_zero;
      end
      UPD_SHIFT: begin
        d.c = cout;
      end
      default: d = q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (en) begin
      q <= d;
    end
  end

endmodule

// File: rtl/cc_cond_eval.sv
module cc_cond_eval
  import cc_pkg::*;
(
  input  flags_t f,
  input  cond_e  cond,
  output logic   hit
);

  logic sgn_ge;

  assign sgn_ge = (f.n == f.v);

  always_comb begin
    unique case (cond)
      CND_ALWAYS: hit = 1'b1;
      CND_NEVER:  hit = 1'b0;
      CND_EQ:     hit = f.z;
      CND_NE:     hit = !f.z;
      CND_GT:     hit = sgn_ge && !f.z;
      CND_LE:     hit = !sgn_ge || f.z;
      CND_GE:     hit = sgn_ge;
      CND_LT:     hit = !sgn_ge;
      CND_UGT:    hit = f.c && !f.z;
      CND_ULE:    hit = !f.c || f.z;
      CND_CCLR:   hit = !f.c;
      CND_CSET:   hit = f.c;
      CND_POS:    hit = !f.n;
      CND_NEG:    hit = f.n;
      CND_VCLR:   hit = !f.v;
      CND_VSET:   hit = f.v;
      default:    hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/cc_target_gen.sv
module cc_target_gen #(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 16,
  parameter int SHIFT  = 2
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [OFS_W-1:0]  ofs,
  output logic [ADDR_W-1:0] target
);

  localparam int EXT_W      = ADDR_W + OFS_W + SHIFT;
  localparam int STEP_BYTES = 1 << SHIFT;

  logic [EXT_W-1:0] pc_ext;
  logic [EXT_W-1:0] ofs_ext;
  logic [EXT_W-1:0] sum;

  assign pc_ext  = {{(EXT_W-ADDR_W){1'b0}}, pc};
  assign ofs_ext = {{(EXT_W-OFS_W){ofs[OFS_W-1]}}, ofs};
  assign sum     = pc_ext + EXT_W'(STEP_BYTES) + (ofs_ext << SHIFT);
  assign target  = sum[ADDR_W-1:0];

endmodule

// File: rtl/cc_branch_unit.sv
module cc_branch_unit
  import cc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        upd_cls,
  input  logic [DATA_W-1:0] alu_res,
  input  logic              alu_cout,
  input  logic              alu_ovf,
  input  logic              br_valid,
  input  logic [3:0]        br_cond,
  input  logic [OFS_W-1:0]  br_ofs,
  input  logic [ADDR_W-1:0] pc,
  output logic              br_taken,
  output logic [ADDR_W-1:0] br_target,
  output logic [3:0]        flags
);

  localparam int INSTR_SHIFT = 2;
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync;
  logic                   rst_int_n;
  flags_t                 flag_q;
  logic                   cond_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= '0;
    end else begin
      rst_sync <= {rst_sync[SYNC_STAGES-2:0], 1'b1};
    end
  end

  assign rst_int_n = rst_sync[SYNC_STAGES-1];

  cc_flag_reg #(
    .DATA_W(DATA_W)
  ) u_flags (
    .clk  (clk),
    .rst_n(rst_int_n),
    .cls  (upd_cls_e'(upd_cls)),
    .res  (alu_res),
    .cout (alu_cout),
    .ovf  (alu_ovf),
    .q    (flag_q)
  );

  cc_cond_eval u_cond (
    .f   (flag_q),
    .cond(cond_e'(br_cond)),
    .hit (cond_hit)
  );

  cc_target_gen #(
    .ADDR_W(ADDR_W),
    .OFS_W (OFS_W),
    .SHIFT (INSTR_SHIFT)
  ) u_tgt (
    .pc    (pc),
    .ofs   (br_ofs),
    .target(br_target)
  );

  assign br_taken = br_valid && cond_hit;
  assign flags    = flag_q;

endmodule

// File: rtl/cc_branch_chk.sv
module cc_branch_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 16
) (
  input logic              clk,
  input logic              rst_int_n,
  input logic [1:0]        upd_cls,
  input logic [DATA_W-1:0] alu_res,
  input logic              alu_cout,
  input logic              alu_ovf,
  input logic              br_valid,
  input logic [3:0]        br_cond,
  input logic [OFS_W-1:0]  br_ofs,
  input logic [ADDR_W-1:0] pc,
  input logic              br_taken,
  input logic [ADDR_W-1:0] br_target,
  input logic [3:0]        flags
);

  // R2
  full_update_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    upd_cls == 2'b01 |=> flags == {$past(alu_res[DATA_W-1]), ($past(alu_res) == '0),
                                   $past(alu_ovf), $past(alu_cout)});

  // R4
  shift_update_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    upd_cls == 2'b11 |=> (flags[3:1] == $past(flags[3:1])) && (flags[0] == $past(alu_cout)));

  // R5
  no_update_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    upd_cls == 2'b00 |=> $stable(flags));

  // R6
  idle_branch_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !br_valid |-> !br_taken);

  // R6
  always_taken_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (br_valid && br_cond == 4'd0) |-> br_taken);

  // R7
  signed_ge_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (br_valid && br_cond == 4'd6) |-> (br_taken == (flags[3] == flags[1])));

  // R9
  zero_ofs_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (br_ofs == '0) |-> (br_target == pc + ADDR_W'(4)));

endmodule

bind cc_branch_unit cc_branch_chk #(
  .DATA_W(DATA_W),
  .ADDR_W(ADDR_W),
  .OFS_W (OFS_W)
) u_chk (
  .clk      (clk),
  .rst_int_n(rst_int_n),
  .upd_cls  (upd_cls),
  .alu_res  (alu_res),
  .alu_cout (alu_cout),
  .alu_ovf  (alu_ovf),
  .br_valid (br_valid),
  .br_cond  (br_cond),
  .br_ofs   (br_ofs),
  .pc       (pc),
  .br_taken (br_taken),
  .br_target(br_target),
  .flags    (flags)
);

// File: tb/cc_branch_unit_bench.sv
module cc_branch_unit_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int AW = 16;
  localparam int OW = 16;

  logic          clk;
  logic          rst_n;
  logic [1:0]    upd_cls;
  logic [DW-1:0] alu_res;
  logic          alu_cout;
  logic          alu_ovf;
  logic          br_valid;
  logic [3:0]    br_cond;
  logic [OW-1:0] br_ofs;
  logic [AW-1:0] pc;
  logic          br_taken;
  logic [AW-1:0] br_target;
  logic [3:0]    flags;

  int n_chk  = 0;
  int n_fail = 0;

  cc_branch_unit #(
    .DATA_W(DW),
    .ADDR_W(AW),
    .OFS_W (OW)
  ) u_cc_branch_unit (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd_cls  (upd_cls),
    .alu_res  (alu_res),
    .alu_cout (alu_cout),
    .alu_ovf  (alu_ovf),
    .br_valid (br_valid),
    .br_cond  (br_cond),
    .br_ofs   (br_ofs),
    .pc       (pc),
    .br_taken (br_taken),
    .br_target(br_target),
    .flags    (flags)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic cond_exp(input logic [3:0] c, input logic [3:0] f);
    logic n, z, v, cy;
    {n, z, v, cy} = f;
    case (c)
      4'd0:    return 1'b1;
      4'd1:    return 1'b0;
      4'd2:    return z;
      4'd3:    return !z;
      4'd4:    return !z && (n == v);
      4'd5:    return z || (n != v);
      4'd6:    return n == v;
      4'd7:    return n != v;
      4'd8:    return cy && !z;
      4'd9:    return !cy || z;
      4'd10:   return !cy;
      4'd11:   return cy;
      4'd12:   return !n;
      4'd13:   return n;
      4'd14:   return !v;
      default: return v;
    endcase
  endfunction

  // Drive one instruction's flag update for one cycle; flags are sampled after the edge.
  task automatic do_upd(input logic [1:0] cls, input logic [DW-1:0] res, input logic co, input logic ov);
    @(negedge clk);
    upd_cls  = cls;
    alu_res  = res;
    alu_cout = co;
    alu_ovf  = ov;
    @(negedge clk);
    upd_cls  = 2'b00;
  endtask

  task automatic set_flags(input logic [3:0] f);
    logic [DW-1:0] res;
    res = f[3] ? DW'(8'h80) : (f[2] ? '0 : DW'(1));
    do_upd(2'b01, res, f[0], f[1]);
    check("R2 full update", 32'(flags), 32'(f));
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    #(CLK_PERIOD * 3);
    check("R1 flags in reset", 32'(flags), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 flags after release", 32'(flags), 32'h0);
  endtask

  task automatic test_classes();
    set_flags(4'b0011);
    do_upd(2'b10, DW'(8'h80), 1'b0, 1'b0);
    check("R3 logic keeps V,C", 32'(flags), 32'hB);
    do_upd(2'b10, '0, 1'b1, 1'b1);
    check("R3 logic zero result", 32'(flags), 32'h7);
    do_upd(2'b11, DW'(8'h80), 1'b0, 1'b0);
    check("R4 shift writes C only", 32'(flags), 32'h6);
    do_upd(2'b11, '0, 1'b1, 1'b0);
    check("R4 shift sets C", 32'(flags), 32'h7);
    do_upd(2'b00, DW'(8'h80), 1'b0, 1'b0);
    check("R5 no update", 32'(flags), 32'h7);
    do_upd(2'b00, '0, 1'b1, 1'b1);
    check("R5 no update again", 32'(flags), 32'h7);
  endtask

  task automatic test_conditions();
    for (int fv = 0; fv < 16; fv++) begin
      if (fv[3] && fv[2]) continue;
      set_flags(4'(fv));
      for (int c = 0; c < 16; c++) begin
        @(negedge clk);
        br_cond  = 4'(c);
        br_valid = 1'b0;
        #1;
        check("R6 invalid not taken", 32'(br_taken), 32'h0);
        br_valid = 1'b1;
        #1;
        if (c < 2)      check("R6 always/never", 32'(br_taken), 32'(cond_exp(4'(c), 4'(fv))));
        else if (c < 8) check("R7 signed cond", 32'(br_taken), 32'(cond_exp(4'(c), 4'(fv))));
        else            check("R8 unsigned/flag cond", 32'(br_taken), 32'(cond_exp(4'(c), 4'(fv))));
        br_valid = 1'b0;
      end
    end
  endtask

  task automatic test_target(input logic [AW-1:0] p, input int ofs);
    int exp;
    @(negedge clk);
    pc     = p;
    br_ofs = OW'(ofs);
    #1;
    exp = (int'(p) + 4 + ofs * 4) & 32'hFFFF;
    check("R9 target", 32'(br_target), 32'(exp));
  endtask

  task automatic test_same_cycle();
    set_flags(4'b0000);
    @(negedge clk);
    upd_cls  = 2'b01;
    alu_res  = '0;
    alu_cout = 1'b0;
    alu_ovf  = 1'b0;
    br_valid = 1'b1;
    br_cond  = 4'd2;
    #1;
    check("R10 uses old flags", 32'(br_taken), 32'h0);
    @(negedge clk);
    upd_cls = 2'b00;
    #1;
    check("R10 new flags next cycle", 32'(br_taken), 32'h1);
    br_valid = 1'b0;
  endtask

  task automatic test_reset_clears();
    set_flags(4'b1011);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 reset clears flags", 32'(flags), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    upd_cls  = 2'b00;
    alu_res  = '0;
    alu_cout = 1'b0;
    alu_ovf  = 1'b0;
    br_valid = 1'b0;
    br_cond  = 4'd0;
    br_ofs   = '0;
    pc       = '0;
    test_reset();
    test_classes();
    test_conditions();
    test_target(16'h1000, 0);
    test_target(16'h1000, 5);
    test_target(16'h1000, -1);
    test_target(16'hFFFC, 1);
    test_target(16'h2000, 32767);
    test_target(16'h2000, -32768);
    test_target(16'h0004, -3);
    test_same_cycle();
    test_reset_clears();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule